// File: doc/BRIEF.md
# Triggered Two-Channel Capture Ring Buffer

This block records fixed-length bursts of converter samples from two channels, called DI and DQ, into on-chip memory. A host starts a burst by writing a control register. The block then stores every sample pair that the converter front end presents until the record is full, and drops back to idle. Each burst goes into the next of sixteen record slots. After the sixteenth slot the block wraps back to the first and writes over the oldest record. Nothing guards against that overwrite.

The front end hands over two 12-bit words per channel in each valid cycle: the word taken on the rising converter edge in the low lane and the word taken on the falling edge in the high lane. The host reads stored words through a word-addressed read port. The DI window and the DQ window each give every slot a fixed 4096-word stride. Read data is zero-extended to 32 bits and appears one clock after the address. The record length is a package constant, `REC_LOG2`. The default of 6 (64 words per record) keeps elaboration small, and production builds set it to 12 (4096 words).

Top module: `capture_ring`

## Requirements
- R1: A cycle with `regWrEn`=1, `regAddr`=0 and `regWrData` bit 13 set, while `captureBusy`=0, starts a capture, and `captureBusy` is 1 after the next clock edge. A write to any other address, or with bit 13 clear, starts nothing.
- R2: `captureBusy` stays 1 until the clock edge that accepts the record's last sample pair (pair REC_WORDS/2-1), and is 0 after that edge.
- R3: A trigger write that arrives while `captureBusy`=1 is ignored. The running record keeps its length and its slot, and no extra slot is consumed.
- R4: In pair k of a record, lane bits 11:0 of `adcDiPair`/`adcDqPair` (the rising-edge word) are stored at word offset 2k, and lane bits 23:12 (the falling-edge word) at offset 2k+1.
- R5: The n-th capture after reset (counting from 0) is stored in slot n mod 16. The 17th capture overwrites slot 0 and leaves slots 1 to 15 unchanged.
- R6: DI word w of slot s is read at address 0x20000 + s*0x1000 + w.
- R7: DQ word w of slot s is read at address 0x30000 + s*0x1000 + w.
- R8: `rdData` reflects the `rdAddr` sampled at a clock edge, after that edge. Bits 11:0 carry the stored word and bits 31:12 are always 0.
- R9: Addresses below 0x20000, and offsets inside a slot at or beyond REC_WORDS, read as 0.
- R10: During a capture, cycles with `adcValid`=0 store nothing and do not advance the record.
- R11: After reset, `captureBusy`=0, `rdData`=0, and the first capture goes to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 18 | Host register write address |
| regWrData | input | 32 | Host register write data |
| adcValid | input | 1 | Sample pair valid this cycle |
| adcDiPair | input | 24 | DI pair: [11:0] rising-edge word, [23:12] falling-edge word |
| adcDqPair | input | 24 | DQ pair, same lane layout |
| rdAddr | input | 18 | Word read address |
| rdData | output | 32 | Read data, registered |
| captureBusy | output | 1 | Capture in progress |

## Verification
A wrong pair counter shows at the ports at once. `captureBusy` falls early or late relative to the last valid pair, and words come back shifted to the wrong offsets on the very next readback. A wrong slot pointer only becomes visible when the ring is read back after several captures: one record sits in another record's window, or the 17th capture fails to replace slot 0. For that reason the bench fills every slot and wraps once before it reads all of them back. Decode faults show up the cycle after the bad address, either as nonzero data outside the windows or as DI and DQ swapped.

// File: rtl/capture_pkg.sv
package capture_pkg;
  localparam int DATA_W      = 12;
  localparam int SLOT_LOG2   = 4;
  localparam int REC_LOG2    = 6;
  localparam int ADDR_W      = 18;
  localparam int BUS_W       = 32;
  localparam int TRIG_BIT    = 13;
  localparam int STRIDE_LOG2 = 12;
  localparam int WIN_LOG2    = 16;

  localparam int PAIR_LOG2 = REC_LOG2 - 1;
  localparam int PAIRS     = 1 << PAIR_LOG2;
  localparam int REC_WORDS = 1 << REC_LOG2;
  localparam int SLOTS     = 1 << SLOT_LOG2;
  localparam int LANE_W    = 2 * DATA_W;
  localparam int DEPTH     = SLOTS * PAIRS;
  localparam int IDX_W     = SLOT_LOG2 + PAIR_LOG2;
  localparam int NCH       = 2;

  typedef struct packed {
    logic                 wrEn;
    logic [SLOT_LOG2-1:0] slot;
    logic [PAIR_LOG2-1:0] pair;
  } wrStrobe_t;
endpackage

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import capture_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWrData,
  input  logic              adcValid,
  output wrStrobe_t         strobe,
  output logic              busy
);
  logic [PAIR_LOG2-1:0] pairCnt;
  logic [SLOT_LOG2-1:0] slotPtr;
  logic                 trigHit;
  logic                 accept;
  logic                 lastPair;

  assign trigHit  = regWrEn && (regAddr == '0) && regWrData[TRIG_BIT];
  assign accept   = busy && adcValid;
  assign lastPair = accept && (&pairCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      pairCnt <= '0;
      slotPtr <= '0;
    end else if (!busy) begin
      if (trigHit) begin
        busy    <= 1'b1;
        pairCnt <= '0;
      end
    end else if (accept) begin
      pairCnt <= pairCnt + PAIR_LOG2'(1);
      if (lastPair) begin
        busy    <= 1'b0;
        slotPtr <= slotPtr + SLOT_LOG2'(1);
      end
    end
  end

  always_comb begin
    strobe.wrEn = accept;
    strobe.slot = slotPtr;
    strobe.pair = pairCnt;
  end
endmodule

// File: rtl/capture_data.sv
module capture_data
  import capture_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [LANE_W-1:0] adcDiPair,
  input  logic [LANE_W-1:0] adcDqPair,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData
);
  logic [LANE_W-1:0] chIn   [NCH];
  logic [LANE_W-1:0] bankOut[NCH];

  logic [STRIDE_LOG2-1:0] rdOff;
  logic [SLOT_LOG2-1:0]   rdSlot;
  logic                   rdInRec;
  logic                   rdHit;
  logic [IDX_W-1:0]       rdIdx;
  logic [IDX_W-1:0]       wrIdx;

  logic       hitQ;
  logic       chQ;
  logic       halfQ;
  logic [DATA_W-1:0] word;

  assign chIn[0] = adcDiPair;
  assign chIn[1] = adcDqPair;

  assign rdOff   = rdAddr[STRIDE_LOG2-1:0];
  assign rdSlot  = rdAddr[STRIDE_LOG2 +: SLOT_LOG2];
  assign rdInRec = ({1'b0, rdOff} < (STRIDE_LOG2+1)'(REC_WORDS));
  assign rdHit   = rdAddr[ADDR_W-1] && rdInRec;
  assign rdIdx   = {rdSlot, rdOff[REC_LOG2-1:1]};
  assign wrIdx   = {strobe.slot, strobe.pair};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_bank
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rdPair;

    always_ff @(posedge clk) begin
      if (strobe.wrEn) mem[wrIdx] <= chIn[ch];
    end

    always_ff @(posedge clk) begin
      rdPair <= mem[rdIdx];
    end

    assign bankOut[ch] = rdPair;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ  <= 1'b0;
      chQ   <= 1'b0;
      halfQ <= 1'b0;
    end else begin
      hitQ  <= rdHit;
      chQ   <= rdAddr[WIN_LOG2];
      halfQ <= rdOff[0];
    end
  end

  always_comb begin
    word   = halfQ ? bankOut[chQ][LANE_W-1:DATA_W] : bankOut[chQ][DATA_W-1:0];
    rdData = hitQ ? {{(BUS_W-DATA_W){1'b0}}, word} : '0;
  end
endmodule

// File: rtl/capture_ring.sv
module capture_ring
  import capture_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWrData,
  input  logic              adcValid,
  input  logic [LANE_W-1:0] adcDiPair,
  input  logic [LANE_W-1:0] adcDqPair,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData,
  output logic              captureBusy
);
  wrStrobe_t strobe;

  capture_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .adcValid  (adcValid),
    .strobe    (strobe),
    .busy      (captureBusy)
  );

  capture_data u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .adcDiPair (adcDiPair),
    .adcDqPair (adcDqPair),
    .rdAddr    (rdAddr),
    .rdData    (rdData)
  );
endmodule

// File: rtl/capture_ring_chk.sv
module capture_ring_chk
  import capture_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [BUS_W-1:0]  regWrData,
  input logic              adcValid,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [BUS_W-1:0]  rdData,
  input logic              captureBusy
);
  logic trig;
  logic [PAIR_LOG2:0] seen;

  assign trig = regWrEn && (regAddr == '0) && regWrData[TRIG_BIT];

  always_ff @(posedge clk) begin
    if (!rstN || !captureBusy) seen <= '0;
    else if (adcValid) seen <= seen + (PAIR_LOG2+1)'(1);
  end

  assert_trig_starts_R1: assert property (@(posedge clk) disable iff (!rstN)
    (trig && !captureBusy) |=> captureBusy);

  assert_rise_needs_trig_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!captureBusy && !trig) |=> !captureBusy);

  assert_ends_on_last_R2: assert property (@(posedge clk) disable iff (!rstN)
    (captureBusy && adcValid && seen == (PAIR_LOG2+1)'(PAIRS-1)) |=> !captureBusy);

  assert_holds_until_last_R3: assert property (@(posedge clk) disable iff (!rstN)
    (captureBusy && !(adcValid && seen == (PAIR_LOG2+1)'(PAIRS-1))) |=> captureBusy);

  assert_idle_gap_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (captureBusy && !adcValid) |=> captureBusy);

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdData[BUS_W-1:DATA_W] == '0);

  assert_outside_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdAddr[ADDR_W-1] |=> rdData == '0);
endmodule

bind capture_ring capture_ring_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .adcValid    (adcValid),
  .rdAddr      (rdAddr),
  .rdData      (rdData),
  .captureBusy (captureBusy)
);

// File: tb/sim_capture_ring.sv
`timescale 1ns/1ps
module sim_capture_ring;
  import capture_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [BUS_W-1:0]  regWrData = '0;
  logic              adcValid = 1'b0;
  logic [LANE_W-1:0] adcDiPair = '0;
  logic [LANE_W-1:0] adcDqPair = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [BUS_W-1:0]  rdData;
  logic              captureBusy;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] model [NCH][SLOTS][REC_WORDS];
  logic [BUS_W-1:0]  expQ[$];
  string             tagQ[$];
  logic [ADDR_W-1:0] addrQ[$];

  always #2 clk = ~clk;

  capture_ring u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .adcValid(adcValid), .adcDiPair(adcDiPair),
    .adcDqPair(adcDqPair), .rdAddr(rdAddr), .rdData(rdData),
    .captureBusy(captureBusy)
  );

  function automatic logic [DATA_W-1:0] mkWord(int id, int ch, int w);
    return DATA_W'(id * 131 + ch * 977 + w * 29 + 7);
  endfunction

  task automatic check(string tag, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // monitor: pops one expected read per edge after the driver pushed it
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [BUS_W-1:0] e;
      string t;
      logic [ADDR_W-1:0] a;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = addrQ.pop_front();
      check($sformatf("%s addr=%h", t, a), rdData, e);
    end
  end

  task automatic pushRead(logic [ADDR_W-1:0] a, logic [BUS_W-1:0] e, string t);
    rdAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    addrQ.push_back(a);
    @(negedge clk);
  endtask

  task automatic regWrite(logic [ADDR_W-1:0] a, logic [BUS_W-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic capture(int id, int slot);
    regWrite('0, 32'h0000_2000);
    check("R1 busy after trigger", 32'(captureBusy), 32'd1);
    for (int k = 0; k < PAIRS; k++) begin
      if (k % 7 == 3) begin
        adcValid = 1'b0;
        adcDiPair = 24'hABCDEF; adcDqPair = 24'h123456;
        @(negedge clk);
      end
      if (k == 5) begin
        regWrEn = 1'b1; regAddr = '0; regWrData = 32'h0000_2000;
      end
      if (k == PAIRS - 1) check("R2 busy before last pair", 32'(captureBusy), 32'd1);
      adcValid = 1'b1;
      for (int ch = 0; ch < NCH; ch++) begin
        model[ch][slot][2*k]   = mkWord(id, ch, 2*k);
        model[ch][slot][2*k+1] = mkWord(id, ch, 2*k+1);
      end
      adcDiPair = {mkWord(id, 0, 2*k+1), mkWord(id, 0, 2*k)};
      adcDqPair = {mkWord(id, 1, 2*k+1), mkWord(id, 1, 2*k)};
      @(negedge clk);
      regWrEn = 1'b0; regWrData = '0;
      if (k == 5) check("R3 retrigger ignored, still busy", 32'(captureBusy), 32'd1);
    end
    adcValid = 1'b0;
    check("R2 busy clears after last pair", 32'(captureBusy), 32'd0);
    // R10 idle valid after capture must not write
    adcDiPair = 24'hFFFFFF; adcDqPair = 24'hFFFFFF;
    @(negedge clk);
  endtask

  task automatic readSlot(int slot, string t);
    for (int ch = 0; ch < NCH; ch++)
      for (int w = 0; w < REC_WORDS; w++)
        pushRead(ADDR_W'((ch == 0 ? 32'h20000 : 32'h30000) + slot * 32'h1000 + w),
                 {{(BUS_W-DATA_W){1'b0}}, model[ch][slot][w]}, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 reset busy", 32'(captureBusy), 32'd0);
    check("R11 reset rdData", rdData, 32'd0);

    regWrite('0, 32'h0000_1000);
    @(negedge clk);
    check("R1 bit13 clear no start", 32'(captureBusy), 32'd0);
    regWrite(ADDR_W'(4), 32'h0000_2000);
    @(negedge clk);
    check("R1 other address no start", 32'(captureBusy), 32'd0);

    capture(0, 0);
    readSlot(0, "R4 R6 R7 R8 R10 R11 first capture slot0");
    pushRead(ADDR_W'(32'h20000 + REC_WORDS), 32'd0, "R9 beyond record DI");
    pushRead(ADDR_W'(32'h30FFF), 32'd0, "R9 beyond record DQ");
    pushRead(ADDR_W'(32'h10005), 32'd0, "R9 below windows");
    pushRead(ADDR_W'(32'h00000), 32'd0, "R9 control address");
    pushRead(ADDR_W'(32'h20001), {20'd0, model[0][0][1]}, "R8 read after zero");

    for (int n = 1; n <= SLOTS; n++) capture(n, n % SLOTS);
    for (int s = 0; s < SLOTS; s++) readSlot(s, "R5 ring contents after wrap");
    repeat (3) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule